// File: doc/BRIEF.md
# Telegram Field Parser

This block sits behind a line decoder on a single-wire, pulse-width-coded polling bus. It receives one symbol at a time (a zero, a one, or a separator) and rebuilds telegrams from that stream. A telegram has one address field and then any number of data fields, and every field has a variable length. The block uses only runs of separators to find the field boundaries. A bit run that follows at least two back-to-back separators is an address. A bit run that follows exactly one separator after a field is data. A second separator in a row closes the telegram.

Incoming bits are shifted in first bit first. The block counts the length of each field. When a field closes, it presents the field value right-aligned, the field length and an overflow flag, together with a one-cycle strobe. A separate flag tells a local transmitter that it may start an address, which is allowed once four or more separators have passed in a row. An abort input discards a partial telegram when the line shows a reset or idle condition.

Top module: `tfp_telegram_parser`

## Requirements
- R1: A symbol is taken when `sign_valid` is high, with `sign_code` 2'b00 = bit 0, 2'b01 = bit 1, 2'b10 = separator. Code 2'b11 is reserved. It changes no field, no length, no separator run and no output.
- R2: A bit that arrives while fewer than two separators in a row have been seen (counted since reset, abort or the last bit), and while no telegram is open, is dropped. A bit after two or more such separators starts an address field.
- R3: The separator that closes an address field makes `addr_valid` pulse for one cycle, one clock after the edge that takes the separator. At that time `addr_len` is the number of bits, and `addr_bits` holds the bits right-aligned with the first received bit at position `addr_len`-1.
- R4: After a field has closed, a bit that follows a single separator starts a data field. Its closing separator pulses `data_valid`, with `data_bits` and `data_len` coded the same way as in R3. A telegram may carry several data fields.
- R5: A separator that directly follows the separator which closed a field pulses `telegram_done` for one cycle. An address-only telegram gives `telegram_done` with no `data_valid` pulse. At most one of the three strobes is high in any cycle.
- R6: A field longer than FIELD_W bits (32 by default) keeps its first FIELD_W bits and reports a length of FIELD_W. `field_ovf` is high together with that field's strobe. A field of exactly FIELD_W bits does not set the flag.
- R7: `ready_to_send` is high from the cycle after the fourth separator in a row has been taken. It stays high until a bit or an abort is taken. After three separators in a row it is low.
- R8: When `line_abort` is high, the open field and telegram are dropped without any strobe, and the separator run is cleared. The next address therefore needs two new separators first.
- R9: During and right after reset, all strobes, `field_ovf` and `ready_to_send` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sign_valid | input | 1 | A decoded symbol is present this cycle |
| sign_code | input | 2 | Symbol: 00 zero, 01 one, 10 separator, 11 reserved |
| line_abort | input | 1 | Line reset/idle seen: drop the partial telegram |
| addr_valid | output | 1 | One-cycle strobe: address field closed |
| addr_bits | output | FIELD_W | Address value, right-aligned |
| addr_len | output | LEN_W | Address length in bits |
| data_valid | output | 1 | One-cycle strobe: data field closed |
| data_bits | output | FIELD_W | Data value, right-aligned |
| data_len | output | LEN_W | Data length in bits |
| field_ovf | output | 1 | The field now being reported was truncated |
| telegram_done | output | 1 | One-cycle strobe: telegram ended validly |
| ready_to_send | output | 1 | Four or more separators in a row seen |

## Verification
A wrong state in the framing control shows up as a strobe of the wrong kind when a separator closes a field. For example, a data strobe appears where an address was expected, or a completion strobe is missing one cycle after the second separator. So a state error is visible within one symbol of the next separator. A wrong separator-run count shows up on `ready_to_send` the cycle after the fourth separator, or as an address that starts or fails to start after too few separators. A fault in the field accumulator shows up as a wrong value, length or overflow flag on the very next strobe.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

   typedef enum logic [1:0] {
      SIGN_ZERO = 2'b00,
      SIGN_ONE  = 2'b01,
      SIGN_SEP  = 2'b10,
      SIGN_RSVD = 2'b11
   } sign_e;

   typedef enum logic [1:0] {
      ST_HUNT = 2'b00,
      ST_ADDR = 2'b01,
      ST_GAP  = 2'b10,
      ST_DATA = 2'b11
   } frame_st_e;

   typedef struct packed {
      logic take;
      logic restart;
      logic emit_addr;
      logic emit_data;
      logic done;
   } frame_ctl_s;

endpackage

// File: rtl/tfp_sep_run.sv
module tfp_sep_run #(
   parameter int START_RUN = 2,
   parameter int SEND_RUN  = 4,
   localparam int RUN_W    = $clog2(SEND_RUN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sep_seen,
   input  logic mark_seen,
   input  logic abort,
   output logic start_ok,
   output logic send_ok
);

   localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(SEND_RUN);
   localparam logic [RUN_W-1:0] START_LIM = RUN_W'(START_RUN);

   generate
      if (START_RUN < 1) begin : g_bad_start
         $error("tfp_sep_run: START_RUN must be at least 1");
      end
      if (SEND_RUN < START_RUN) begin : g_bad_send
         $error("tfp_sep_run: SEND_RUN must not be below START_RUN");
      end
   endgenerate

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n || abort || mark_seen) begin
         run_q <= '0;
      end else if (sep_seen && (run_q != RUN_MAX)) begin
         run_q <= run_q + 1'b1;
      end
   end

   assign start_ok = (run_q >= START_LIM);
   assign send_ok  = (run_q == RUN_MAX);

endmodule

// File: rtl/tfp_field_acc.sv
module tfp_field_acc #(
   parameter int FIELD_W = 32,
   localparam int LEN_W  = $clog2(FIELD_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic               restart,
   input  logic               bit_in,
   output logic [FIELD_W-1:0] bits,
   output logic [LEN_W-1:0]   len,
   output logic               ovf
);

   localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(FIELD_W);

   generate
      if (FIELD_W < 2) begin : g_bad_width
         $error("tfp_field_acc: FIELD_W must be at least 2");
      end
   endgenerate

   logic [FIELD_W-1:0] bits_q;
   logic [LEN_W-1:0]   len_q;
   logic               ovf_q;
   logic               full;

   assign full = (len_q == LEN_FULL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
         len_q  <= '0;
         ovf_q  <= 1'b0;
      end else if (take && restart) begin
         bits_q <= {{(FIELD_W-1){1'b0}}, bit_in};
         len_q  <= LEN_W'(1);
         ovf_q  <= 1'b0;
      end else if (take && full) begin
         ovf_q  <= 1'b1;
      end else if (take) begin
         bits_q <= {bits_q[FIELD_W-2:0], bit_in};
         len_q  <= len_q + 1'b1;
      end
   end

   assign bits = bits_q;
   assign len  = len_q;
   assign ovf  = ovf_q;

endmodule

// File: rtl/tfp_frame_ctrl.sv
module tfp_frame_ctrl
   import tfp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sign_valid,
   input  logic [1:0] sign_code,
   input  logic       abort,
   input  logic       start_ok,
   output logic       sep_seen,
   output logic       mark_seen,
   output frame_ctl_s ctl
);

   frame_st_e st_q, st_d;
   logic      is_bit, is_sep;

   assign is_bit    = sign_valid && ((sign_code == SIGN_ZERO) || (sign_code == SIGN_ONE));
   assign is_sep    = sign_valid && (sign_code == SIGN_SEP);
   assign sep_seen  = is_sep && !abort;
   assign mark_seen = is_bit && !abort;

   always_comb begin
      st_d = st_q;
      ctl  = '0;
      if (abort) begin
         st_d = ST_HUNT;
      end else if (is_bit) begin
         unique case (st_q)
            ST_HUNT: if (start_ok) begin
               ctl.take    = 1'b1;
               ctl.restart = 1'b1;
               st_d        = ST_ADDR;
            end
            ST_ADDR, ST_DATA: ctl.take = 1'b1;
            ST_GAP: begin
               ctl.take    = 1'b1;
               ctl.restart = 1'b1;
               st_d        = ST_DATA;
            end
            default: st_d = ST_HUNT;
         endcase
      end else if (is_sep) begin
         unique case (st_q)
            ST_HUNT: st_d = ST_HUNT;
            ST_ADDR: begin
               ctl.emit_addr = 1'b1;
               st_d          = ST_GAP;
            end
            ST_DATA: begin
               ctl.emit_data = 1'b1;
               st_d          = ST_GAP;
            end
            ST_GAP: begin
               ctl.done = 1'b1;
               st_d     = ST_HUNT;
            end
            default: st_d = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_HUNT;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/tfp_telegram_parser.sv
module tfp_telegram_parser
   import tfp_pkg::*;
#(
   parameter int FIELD_W   = 32,
   parameter int START_RUN = 2,
   parameter int SEND_RUN  = 4,
   localparam int LEN_W    = $clog2(FIELD_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sign_valid,
   input  logic [1:0]         sign_code,
   input  logic               line_abort,
   output logic               addr_valid,
   output logic [FIELD_W-1:0] addr_bits,
   output logic [LEN_W-1:0]   addr_len,
   output logic               data_valid,
   output logic [FIELD_W-1:0] data_bits,
   output logic [LEN_W-1:0]   data_len,
   output logic               field_ovf,
   output logic               telegram_done,
   output logic               ready_to_send
);

   frame_ctl_s         ctl;
   logic               sep_seen, mark_seen, start_ok, send_ok;
   logic [FIELD_W-1:0] acc_bits;
   logic [LEN_W-1:0]   acc_len;
   logic               acc_ovf;

   tfp_frame_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sign_valid (sign_valid),
      .sign_code  (sign_code),
      .abort      (line_abort),
      .start_ok   (start_ok),
      .sep_seen   (sep_seen),
      .mark_seen  (mark_seen),
      .ctl        (ctl)
   );

   tfp_sep_run #(
      .START_RUN (START_RUN),
      .SEND_RUN  (SEND_RUN)
   ) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .sep_seen  (sep_seen),
      .mark_seen (mark_seen),
      .abort     (line_abort),
      .start_ok  (start_ok),
      .send_ok   (send_ok)
   );

   tfp_field_acc #(
      .FIELD_W (FIELD_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (ctl.take),
      .restart (ctl.restart),
      .bit_in  (sign_code[0]),
      .bits    (acc_bits),
      .len     (acc_len),
      .ovf     (acc_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_valid    <= 1'b0;
         data_valid    <= 1'b0;
         telegram_done <= 1'b0;
         field_ovf     <= 1'b0;
         addr_bits     <= '0;
         addr_len      <= '0;
         data_bits     <= '0;
         data_len      <= '0;
      end else begin
         addr_valid    <= ctl.emit_addr;
         data_valid    <= ctl.emit_data;
         telegram_done <= ctl.done;
         field_ovf     <= (ctl.emit_addr || ctl.emit_data) && acc_ovf;
         if (ctl.emit_addr) begin
            addr_bits <= acc_bits;
            addr_len  <= acc_len;
         end
         if (ctl.emit_data) begin
            data_bits <= acc_bits;
            data_len  <= acc_len;
         end
      end
   end

   assign ready_to_send = send_ok;

endmodule

// File: rtl/tfp_telegram_parser_chk.sv
module tfp_telegram_parser_chk #(
   parameter int FIELD_W = 32,
   parameter int LEN_W   = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sign_valid,
   input logic [1:0]         sign_code,
   input logic               line_abort,
   input logic               addr_valid,
   input logic [LEN_W-1:0]   addr_len,
   input logic               data_valid,
   input logic [LEN_W-1:0]   data_len,
   input logic               field_ovf,
   input logic               telegram_done,
   input logic               ready_to_send
);

   logic in_bit, in_sep, in_rsvd;
   assign in_bit  = sign_valid && !sign_code[1] && !line_abort;
   assign in_sep  = sign_valid && (sign_code == 2'b10) && !line_abort;
   assign in_rsvd = sign_valid && (sign_code == 2'b11) && !line_abort;

   a_r1_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      in_rsvd |=> (!addr_valid && !data_valid && !telegram_done && $stable(ready_to_send)));

   a_r2_bit_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      in_bit |=> (!addr_valid && !data_valid && !telegram_done));

   a_r3_addr_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> (addr_len != '0) && (addr_len <= LEN_W'(FIELD_W)));

   a_r4_data_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (data_len != '0) && (data_len <= LEN_W'(FIELD_W)));

   a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_valid, data_valid, telegram_done}));

   a_r5_done_after_sep: assert property (@(posedge clk) disable iff (!rst_n)
      telegram_done |-> $past(in_sep));

   a_r6_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
      field_ovf |-> ((addr_valid && addr_len == LEN_W'(FIELD_W)) ||
                     (data_valid && data_len == LEN_W'(FIELD_W))));

   a_r7_rise_after_sep: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_to_send) |-> $past(in_sep));

   a_r7_bit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      in_bit |=> !ready_to_send);

   a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      line_abort |=> (!addr_valid && !data_valid && !telegram_done && !ready_to_send && !field_ovf));

endmodule

bind tfp_telegram_parser tfp_telegram_parser_chk #(
   .FIELD_W (FIELD_W),
   .LEN_W   (LEN_W)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sign_valid    (sign_valid),
   .sign_code     (sign_code),
   .line_abort    (line_abort),
   .addr_valid    (addr_valid),
   .addr_len      (addr_len),
   .data_valid    (data_valid),
   .data_len      (data_len),
   .field_ovf     (field_ovf),
   .telegram_done (telegram_done),
   .ready_to_send (ready_to_send)
);

// File: tb/test_tfp_telegram_parser.sv
`timescale 1ns/1ps
module test_tfp_telegram_parser;

   localparam int FW = 32;
   localparam int LW = 6;

   typedef struct packed {
      logic [5:0]  alen;
      logic [31:0] aval;
      logic [1:0]  nd;
      logic [5:0]  l0;
      logic [31:0] v0;
      logic [5:0]  l1;
      logic [31:0] v1;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{6'd3,  32'h0000_0005, 2'd0, 6'd0,  32'h0,          6'd0, 32'h0},
      '{6'd1,  32'h0000_0000, 2'd1, 6'd4,  32'h0000_000C,  6'd0, 32'h0},
      '{6'd8,  32'h0000_00A5, 2'd2, 6'd4,  32'h0000_0009,  6'd5, 32'h0000_0016},
      '{6'd32, 32'hDEAD_BEEF, 2'd1, 6'd32, 32'h0000_0001,  6'd0, 32'h0},
      '{6'd2,  32'h0000_0003, 2'd2, 6'd1,  32'h0000_0001,  6'd6, 32'h0000_0000},
      '{6'd5,  32'h0000_000A, 2'd1, 6'd16, 32'h0000_F00F,  6'd0, 32'h0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sign_valid = 1'b0;
   logic [1:0]    sign_code = 2'b00;
   logic          line_abort = 1'b0;
   logic          addr_valid, data_valid, field_ovf, telegram_done, ready_to_send;
   logic [FW-1:0] addr_bits, data_bits;
   logic [LW-1:0] addr_len, data_len;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   tfp_telegram_parser i_tfp_telegram_parser (
      .clk(clk), .rst_n(rst_n), .sign_valid(sign_valid), .sign_code(sign_code),
      .line_abort(line_abort), .addr_valid(addr_valid), .addr_bits(addr_bits),
      .addr_len(addr_len), .data_valid(data_valid), .data_bits(data_bits),
      .data_len(data_len), .field_ovf(field_ovf), .telegram_done(telegram_done),
      .ready_to_send(ready_to_send)
   );

   // strobe capture, sampled away from the active edge
   int          n_addr = 0, n_done = 0, n_data = 0;
   logic [31:0] c_aval;
   logic [5:0]  c_alen;
   logic        c_aovf;
   logic [31:0] c_dval [4];
   logic [5:0]  c_dlen [4];
   logic        c_dovf [4];

   always @(negedge clk) begin
      if (addr_valid) begin
         n_addr++;
         c_aval = addr_bits; c_alen = addr_len; c_aovf = field_ovf;
         n_data = 0;
      end
      if (data_valid) begin
         if (n_data < 4) begin
            c_dval[n_data] = data_bits; c_dlen[n_data] = data_len; c_dovf[n_data] = field_ovf;
         end
         n_data++;
      end
      if (telegram_done) n_done++;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] code);
      @(negedge clk);
      sign_valid = 1'b1;
      sign_code  = code;
      @(negedge clk);
      sign_valid = 1'b0;
   endtask

   task automatic seps(input int n);
      for (int i = 0; i < n; i++) send(2'b10);
   endtask

   task automatic field(input int len, input logic [31:0] val);
      for (int i = len - 1; i >= 0; i--) send(val[i] ? 2'b01 : 2'b00);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int ba, bd;
      // R9: reset state
      idle(3);
      chk("R9 addr_valid", 64'(addr_valid), 0);
      chk("R9 data_valid", 64'(data_valid), 0);
      chk("R9 telegram_done", 64'(telegram_done), 0);
      chk("R9 ready_to_send", 64'(ready_to_send), 0);
      chk("R9 field_ovf", 64'(field_ovf), 0);
      rst_n = 1'b1;
      idle(1);

      // R2: bits after a single separator are dropped
      ba = n_addr; bd = n_done;
      seps(1);
      field(2, 32'h2);
      seps(1);
      field(1, 32'h1);
      seps(2);
      idle(2);
      chk("R2 no address after short run", 64'(n_addr - ba), 0);
      chk("R2 no done outside telegram", 64'(n_done - bd), 0);

      // R7: ready threshold
      seps(1);
      chk("R7 ready low after three", 64'(ready_to_send), 0);
      seps(1);
      chk("R7 ready high after four", 64'(ready_to_send), 1);

      // vector table: R3 R4 R5
      for (int v = 0; v < NVEC; v++) begin
         ba = n_addr; bd = n_done;
         seps(4);
         chk("R7 ready before address", 64'(ready_to_send), 1);
         field(int'(VECS[v].alen), VECS[v].aval);
         chk("R7 ready cleared by bit", 64'(ready_to_send), 0);
         seps(1);
         if (VECS[v].nd > 0) begin
            field(int'(VECS[v].l0), VECS[v].v0);
            seps(1);
         end
         if (VECS[v].nd > 1) begin
            field(int'(VECS[v].l1), VECS[v].v1);
            seps(1);
         end
         seps(1);
         idle(2);
         chk($sformatf("R3 v%0d addr count", v), 64'(n_addr - ba), 1);
         chk($sformatf("R3 v%0d addr value", v), 64'(c_aval), 64'(VECS[v].aval));
         chk($sformatf("R3 v%0d addr len", v), 64'(c_alen), 64'(VECS[v].alen));
         chk($sformatf("R6 v%0d addr no ovf", v), 64'(c_aovf), 0);
         chk($sformatf("R4 v%0d data count", v), 64'(n_data), 64'(VECS[v].nd));
         if (VECS[v].nd > 0) begin
            chk($sformatf("R4 v%0d data0 value", v), 64'(c_dval[0]), 64'(VECS[v].v0));
            chk($sformatf("R4 v%0d data0 len", v), 64'(c_dlen[0]), 64'(VECS[v].l0));
            chk($sformatf("R6 v%0d data0 no ovf", v), 64'(c_dovf[0]), 0);
         end
         if (VECS[v].nd > 1) begin
            chk($sformatf("R4 v%0d data1 value", v), 64'(c_dval[1]), 64'(VECS[v].v1));
            chk($sformatf("R4 v%0d data1 len", v), 64'(c_dlen[1]), 64'(VECS[v].l1));
         end
         chk($sformatf("R5 v%0d done count", v), 64'(n_done - bd), 1);
      end

      // R6: 34-bit address keeps first 32 bits
      ba = n_addr;
      seps(2);
      field(32, 32'h8000_0001);
      field(2, 32'h3);
      seps(2);
      idle(2);
      chk("R6 ovf addr count", 64'(n_addr - ba), 1);
      chk("R6 ovf addr value", 64'(c_aval), 64'h8000_0001);
      chk("R6 ovf addr len", 64'(c_alen), 32);
      chk("R6 ovf flag", 64'(c_aovf), 1);

      // R1: reserved code inside an address is ignored
      ba = n_addr;
      seps(2);
      send(2'b01);
      send(2'b11);
      send(2'b00);
      seps(2);
      idle(2);
      chk("R1 rsvd addr count", 64'(n_addr - ba), 1);
      chk("R1 rsvd addr len", 64'(c_alen), 2);
      chk("R1 rsvd addr value", 64'(c_aval), 64'h2);

      // R8: abort drops partial telegram and the separator run
      ba = n_addr; bd = n_done;
      seps(4);
      field(3, 32'h5);
      @(negedge clk);
      line_abort = 1'b1;
      @(negedge clk);
      line_abort = 1'b0;
      chk("R8 ready low after abort", 64'(ready_to_send), 0);
      field(2, 32'h1);
      seps(2);
      idle(2);
      chk("R8 no address after abort", 64'(n_addr - ba), 0);
      chk("R8 no done after abort", 64'(n_done - bd), 0);
      seps(4);
      @(negedge clk);
      line_abort = 1'b1;
      @(negedge clk);
      line_abort = 1'b0;
      chk("R8 abort clears ready", 64'(ready_to_send), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule